// File: doc/BRIEF.md
# Memory-Operand Instruction Cracker

This block takes one already-decoded instruction whose memory operand may be complex and turns it into a short run of simple micro-operations. The run is emitted one micro-op per cycle over a valid/ready output handshake. Three instruction classes are accepted: a load from memory into a register, a store from a register to memory, and an add whose destination is memory. An address is formed from a base register and a displacement, and optionally from an index register scaled by 1, 2, 4 or 8.

Simple base-plus-displacement forms pass straight through as a single ld or st. Indexed forms first build the address in a fixed scratch register with mov, an optional shl, and add. They then access memory relative to that scratch register. An add to memory becomes a load into scratch, an add of the source register into scratch, and a store of scratch back to the same address.

The instruction is captured on acceptance, so the producer is free once its valid has been taken. No new instruction is accepted until the consumer has taken the final micro-op of the current run, which is marked with a last flag.

Top module: `uop_cracker`

## Requirements
- R1: After reset `out_valid_o` is low and `in_ready_o` is high.
- R2: An instruction is accepted on a cycle with `in_valid_i` and `in_ready_o` both high, and its fields are captured. `in_ready_o` is low from the cycle after acceptance until the cycle after the last micro-op is taken. Input changes while busy have no effect on the run.
- R3: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and the op, rd, rs, imm and last outputs hold their values.
- R4: A load (class code 0) without index becomes one micro-op: ld (op code 0) with rd = data register, rs = base, and imm = displacement. A zero displacement gives imm 0.
- R5: A store (class code 1) without index becomes one micro-op: st (op code 1) with rd = data register, rs = base, and imm = displacement.
- R6: A load or store with an index, and a scale field of 0, becomes three micro-ops in this order. First, mov (op code 3) with rd = scratch, rs = index, imm 0. Second, add (op code 2) with rd = scratch, rs = base, imm 0. Third, ld or st with rd = data register, rs = scratch, imm = displacement.
- R7: The scale field holds log2 of the scale factor (0..3 for 1, 2, 4, 8). A nonzero field inserts shl (op code 4) with rd = rs = scratch and imm = field value, placed between the mov and the base add.
- R8: An add to memory (class code 2) becomes three micro-ops in this order. First, ld with rd = scratch, rs = base, imm = displacement. Second, add with rd = scratch, rs = data register, imm 0. Third, st with rd = scratch, rs = base, imm = displacement. The index enable, index register and scale fields are ignored for this class.
- R9: `out_last_o` is high on the final micro-op of each run and low on every other micro-op.
- R10: The scratch register number is the parameter `SCRATCH_REG`, default 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Instruction offered |
| in_ready_o | output | 1 | Cracker idle, can accept |
| in_cls_i | input | 2 | Class: 0 load, 1 store, 2 add to memory |
| in_reg_i | input | REG_W | Data register (load destination, store source, add source) |
| in_base_i | input | REG_W | Base register |
| in_has_idx_i | input | 1 | Index register present |
| in_idx_i | input | REG_W | Index register |
| in_scale_i | input | 2 | log2 of the scale factor |
| in_disp_i | input | DISP_W | Displacement |
| out_valid_o | output | 1 | Micro-op presented |
| out_ready_i | input | 1 | Consumer takes the micro-op |
| out_op_o | output | 3 | Micro-op: 0 ld, 1 st, 2 add, 3 mov, 4 shl |
| out_rd_o | output | REG_W | Destination register, or data register for st |
| out_rs_o | output | REG_W | Source or address-base register |
| out_imm_o | output | DISP_W | Immediate: offset or shift amount |
| out_last_o | output | 1 | Final micro-op of the run |

## Verification
The assertions check the handshake rules on every cycle. Acceptance must be followed by a busy state. A stalled micro-op must hold its fields. A non-final take must be followed by another micro-op, and a final take must free the input. Every shl and mov must target the scratch register, with shift amounts in range. The bench scenarios are the only place the order and contents of each expanded run are shown. They cover the load, store and add-to-memory forms, each scale value, the ignored index fields and the effect of a non-default scratch parameter.

// File: rtl/uop_crack_pkg.sv
package uop_crack_pkg;
  typedef enum logic [1:0] {CLS_LOAD = 2'd0, CLS_STORE = 2'd1, CLS_ADDM = 2'd2} cls_e;
  typedef enum logic [2:0] {
    UOP_LD = 3'd0, UOP_ST = 3'd1, UOP_ADD = 3'd2, UOP_MOV = 3'd3, UOP_SHL = 3'd4
  } uop_e;
  typedef enum logic [2:0] {
    PH_MOV = 3'd0, PH_SHL = 3'd1, PH_ADDB = 3'd2,
    PH_MEM0 = 3'd3, PH_MEM1 = 3'd4, PH_MEM2 = 3'd5
  } phase_e;
endpackage

// File: rtl/uop_hold.sv
module uop_hold #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/uop_seq.sv
module uop_seq
  import uop_crack_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       take_i,
  input  logic       last_i,
  input  logic [1:0] new_cls_i,
  input  logic       new_has_idx_i,
  input  logic [1:0] cur_cls_i,
  input  logic [1:0] cur_scale_i,
  output logic       busy_o,
  output phase_e     phase_o
);
  phase_e first_ph, next_ph;

  // add-to-memory never uses the index path
  always_comb begin
    first_ph = (new_has_idx_i && new_cls_i != CLS_ADDM) ? PH_MOV : PH_MEM0;
  end

  always_comb begin
    unique case (phase_o)
      PH_MOV:  next_ph = (cur_scale_i != 2'd0) ? PH_SHL : PH_ADDB;
      PH_SHL:  next_ph = PH_ADDB;
      PH_ADDB: next_ph = PH_MEM0;
      PH_MEM0: next_ph = (cur_cls_i == CLS_ADDM) ? PH_MEM1 : PH_MEM0;
      PH_MEM1: next_ph = PH_MEM2;
      default: next_ph = PH_MEM0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o  <= 1'b0;
      phase_o <= PH_MEM0;
    end else if (accept_i) begin
      busy_o  <= 1'b1;
      phase_o <= first_ph;
    end else if (take_i) begin
      if (last_i) busy_o <= 1'b0;
      else        phase_o <= next_ph;
    end
  end
endmodule

// File: rtl/uop_gen.sv
module uop_gen
  import uop_crack_pkg::*;
#(
  parameter int REG_W       = 4,
  parameter int DISP_W      = 16,
  parameter int SCRATCH_REG = 3
) (
  input  phase_e              phase_i,
  input  logic [1:0]          cls_i,
  input  logic [REG_W-1:0]    reg_i,
  input  logic [REG_W-1:0]    base_i,
  input  logic                has_idx_i,
  input  logic [REG_W-1:0]    idx_i,
  input  logic [1:0]          scale_i,
  input  logic [DISP_W-1:0]   disp_i,
  output logic [2:0]          op_o,
  output logic [REG_W-1:0]    rd_o,
  output logic [REG_W-1:0]    rs_o,
  output logic [DISP_W-1:0]   imm_o,
  output logic                last_o
);
  localparam logic [REG_W-1:0] SCR = REG_W'(SCRATCH_REG);

  logic             addm;
  logic [REG_W-1:0] abase;

  assign addm  = (cls_i == CLS_ADDM);
  assign abase = (has_idx_i && !addm) ? SCR : base_i;

  always_comb begin
    op_o   = UOP_LD;
    rd_o   = SCR;
    rs_o   = SCR;
    imm_o  = '0;
    last_o = 1'b0;
    unique case (phase_i)
      PH_MOV: begin
        op_o = UOP_MOV;
        rs_o = idx_i;
      end
      PH_SHL: begin
        op_o  = UOP_SHL;
        imm_o = {{(DISP_W-2){1'b0}}, scale_i};
      end
      PH_ADDB: begin
        op_o = UOP_ADD;
        rs_o = base_i;
      end
      PH_MEM0: begin
        op_o   = (cls_i == CLS_STORE) ? UOP_ST : UOP_LD;
        rd_o   = addm ? SCR : reg_i;
        rs_o   = abase;
        imm_o  = disp_i;
        last_o = !addm;
      end
      PH_MEM1: begin
        op_o = UOP_ADD;
        rs_o = reg_i;
      end
      default: begin
        op_o   = UOP_ST;
        rs_o   = base_i;
        imm_o  = disp_i;
        last_o = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/uop_cracker.sv
module uop_cracker
  import uop_crack_pkg::*;
#(
  parameter int NUM_REGS    = 16,
  parameter int DISP_W      = 16,
  parameter int SCRATCH_REG = 3,
  localparam int REG_W      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [1:0]        in_cls_i,
  input  logic [REG_W-1:0]  in_reg_i,
  input  logic [REG_W-1:0]  in_base_i,
  input  logic              in_has_idx_i,
  input  logic [REG_W-1:0]  in_idx_i,
  input  logic [1:0]        in_scale_i,
  input  logic [DISP_W-1:0] in_disp_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [2:0]        out_op_o,
  output logic [REG_W-1:0]  out_rd_o,
  output logic [REG_W-1:0]  out_rs_o,
  output logic [DISP_W-1:0] out_imm_o,
  output logic              out_last_o
);
  localparam int HOLD_W = 2 + 3*REG_W + 1 + 2 + DISP_W;

  logic              busy, accept, take;
  phase_e            phase;
  logic [HOLD_W-1:0] hold_d, hold_q;
  logic [1:0]        h_cls, h_scale;
  logic [REG_W-1:0]  h_reg, h_base, h_idx;
  logic              h_has_idx;
  logic [DISP_W-1:0] h_disp;

  assign in_ready_o  = !busy;
  assign out_valid_o = busy;
  assign accept      = in_valid_i && !busy;
  assign take        = busy && out_ready_i;

  assign hold_d = {in_cls_i, in_reg_i, in_base_i, in_has_idx_i, in_idx_i, in_scale_i, in_disp_i};
  assign {h_cls, h_reg, h_base, h_has_idx, h_idx, h_scale, h_disp} = hold_q;

  uop_hold #(.W(HOLD_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .d_i    (hold_d),
    .q_o    (hold_q)
  );

  uop_seq u_seq (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .accept_i      (accept),
    .take_i        (take),
    .last_i        (out_last_o),
    .new_cls_i     (in_cls_i),
    .new_has_idx_i (in_has_idx_i),
    .cur_cls_i     (h_cls),
    .cur_scale_i   (h_scale),
    .busy_o        (busy),
    .phase_o       (phase)
  );

  uop_gen #(.REG_W(REG_W), .DISP_W(DISP_W), .SCRATCH_REG(SCRATCH_REG)) u_gen (
    .phase_i   (phase),
    .cls_i     (h_cls),
    .reg_i     (h_reg),
    .base_i    (h_base),
    .has_idx_i (h_has_idx),
    .idx_i     (h_idx),
    .scale_i   (h_scale),
    .disp_i    (h_disp),
    .op_o      (out_op_o),
    .rd_o      (out_rd_o),
    .rs_o      (out_rs_o),
    .imm_o     (out_imm_o),
    .last_o    (out_last_o)
  );
endmodule

// File: rtl/uop_cracker_chk.sv
module uop_cracker_chk #(
  parameter int REG_W       = 4,
  parameter int DISP_W      = 16,
  parameter int SCRATCH_REG = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [2:0]        out_op_o,
  input logic [REG_W-1:0]  out_rd_o,
  input logic [REG_W-1:0]  out_rs_o,
  input logic [DISP_W-1:0] out_imm_o,
  input logic              out_last_o
);
  localparam logic [REG_W-1:0] SCR = REG_W'(SCRATCH_REG);

  AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o && !in_ready_o); // R2
  AST_LAST_FREES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> in_ready_o); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_op_o) && $stable(out_rd_o)
      && $stable(out_rs_o) && $stable(out_imm_o) && $stable(out_last_o)); // R3
  AST_MID_CONTINUES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !out_last_o |=> out_valid_o && !in_ready_o); // R9
  AST_SHL_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_op_o == 3'd4 |-> out_rd_o == SCR && out_rs_o == SCR
      && out_imm_o != '0 && out_imm_o < DISP_W'(4) && !out_last_o); // R7
  AST_MOV_SCRATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_op_o == 3'd3 |-> out_rd_o == SCR && !out_last_o); // R10
endmodule

bind uop_cracker uop_cracker_chk #(.REG_W(REG_W), .DISP_W(DISP_W), .SCRATCH_REG(SCRATCH_REG)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_op_o    (out_op_o),
  .out_rd_o    (out_rd_o),
  .out_rs_o    (out_rs_o),
  .out_imm_o   (out_imm_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_uop_cracker.sv
module tb_uop_cracker;
  localparam int CLK_PERIOD = 10;
  localparam int REG_W  = 4;
  localparam int DISP_W = 16;
  localparam int WD_CYCLES = 5000;

  localparam int OP_LD = 0, OP_ST = 1, OP_ADD = 2, OP_MOV = 3, OP_SHL = 4;
  localparam int SCR = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic in_valid = 1'b0;
  logic [1:0] in_cls = '0;
  logic [REG_W-1:0] in_reg = '0, in_base = '0, in_idx = '0;
  logic in_has_idx = 1'b0;
  logic [1:0] in_scale = '0;
  logic [DISP_W-1:0] in_disp = '0;
  logic out_ready = 1'b0;

  logic in_ready, out_valid, out_last;
  logic [2:0] out_op;
  logic [REG_W-1:0] out_rd, out_rs;
  logic [DISP_W-1:0] out_imm;

  logic in_ready2, out_valid2, out_last2;
  logic [2:0] out_op2;
  logic [REG_W-1:0] out_rd2, out_rs2;
  logic [DISP_W-1:0] out_imm2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uop_cracker #(.NUM_REGS(16), .DISP_W(DISP_W), .SCRATCH_REG(SCR)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_cls_i(in_cls), .in_reg_i(in_reg), .in_base_i(in_base), .in_has_idx_i(in_has_idx),
    .in_idx_i(in_idx), .in_scale_i(in_scale), .in_disp_i(in_disp),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_op_o(out_op),
    .out_rd_o(out_rd), .out_rs_o(out_rs), .out_imm_o(out_imm), .out_last_o(out_last)
  );

  uop_cracker #(.NUM_REGS(16), .DISP_W(DISP_W), .SCRATCH_REG(9)) dut_alt (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready2),
    .in_cls_i(in_cls), .in_reg_i(in_reg), .in_base_i(in_base), .in_has_idx_i(in_has_idx),
    .in_idx_i(in_idx), .in_scale_i(in_scale), .in_disp_i(in_disp),
    .out_valid_o(out_valid2), .out_ready_i(out_ready), .out_op_o(out_op2),
    .out_rd_o(out_rd2), .out_rs_o(out_rs2), .out_imm_o(out_imm2), .out_last_o(out_last2)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // drive one instruction at a negedge, then scramble inputs once it is captured
  task automatic issue(input int cls, input int rg, input int base, input bit hi,
                       input int idx, input int sc, input int disp);
    in_cls = 2'(cls); in_reg = REG_W'(rg); in_base = REG_W'(base); in_has_idx = hi;
    in_idx = REG_W'(idx); in_scale = 2'(sc); in_disp = DISP_W'(disp);
    in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    in_cls = ~in_cls; in_reg = ~in_reg; in_base = ~in_base; in_has_idx = ~in_has_idx;
    in_idx = ~in_idx; in_scale = ~in_scale; in_disp = ~in_disp;
    chk("R2", "in_ready busy", int'(in_ready), 0);
  endtask

  task automatic take(input string req, input int op, input int rd, input int rs,
                      input int imm, input bit last);
    chk(req, "valid", int'(out_valid), 1);
    chk(req, "op", int'(out_op), op);
    chk(req, "rd", int'(out_rd), rd);
    chk(req, "rs", int'(out_rs), rs);
    chk(req, "imm", int'(out_imm), imm);
    chk("R9", "last", int'(out_last), int'(last));
    out_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    out_ready = 1'b0;
    if (last) chk("R2", "in_ready after last", int'(in_ready), 1);
  endtask

  task automatic t_load_plain();   // R4
    issue(0, 5, 7, 0, 0, 0, 0);
    take("R4", OP_LD, 5, 7, 0, 1);
    issue(0, 2, 11, 0, 0, 0, 'h40);
    take("R4", OP_LD, 2, 11, 'h40, 1);
  endtask

  task automatic t_store_plain();  // R5
    issue(1, 6, 12, 0, 0, 0, 'h1234);
    take("R5", OP_ST, 6, 12, 'h1234, 1);
  endtask

  task automatic t_load_idx();     // R6
    issue(0, 8, 1, 1, 4, 0, 'h40);
    take("R6", OP_MOV, SCR, 4, 0, 0);
    take("R6", OP_ADD, SCR, 1, 0, 0);
    take("R6", OP_LD, 8, SCR, 'h40, 1);
  endtask

  task automatic t_store_scaled(); // R7
    issue(1, 0, 2, 1, 10, 2, 'h8);
    take("R7", OP_MOV, SCR, 10, 0, 0);
    take("R7", OP_SHL, SCR, SCR, 2, 0);
    take("R7", OP_ADD, SCR, 2, 0, 0);
    take("R7", OP_ST, 0, SCR, 'h8, 1);
    issue(0, 14, 13, 1, 15, 3, 'hFFFC);
    take("R7", OP_MOV, SCR, 15, 0, 0);
    take("R7", OP_SHL, SCR, SCR, 3, 0);
    take("R7", OP_ADD, SCR, 13, 0, 0);
    take("R7", OP_LD, 14, SCR, 'hFFFC, 1);
  endtask

  task automatic t_addm();         // R8, index fields set but ignored
    issue(2, 4, 9, 1, 6, 2, 'h20);
    take("R8", OP_LD, SCR, 9, 'h20, 0);
    take("R8", OP_ADD, SCR, 4, 0, 0);
    take("R8", OP_ST, SCR, 9, 'h20, 1);
  endtask

  task automatic t_stall();        // R3
    issue(0, 3, 5, 1, 7, 1, 'h10);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3", "stall valid", int'(out_valid), 1);
      chk("R3", "stall op", int'(out_op), OP_MOV);
      chk("R3", "stall rs", int'(out_rs), 7);
    end
    take("R3", OP_MOV, SCR, 7, 0, 0);
    @(negedge clk);
    chk("R3", "stall shl imm", int'(out_imm), 1);
    take("R3", OP_SHL, SCR, SCR, 1, 0);
    take("R3", OP_ADD, SCR, 5, 0, 0);
    take("R3", OP_LD, 3, SCR, 'h10, 1);
  endtask

  task automatic t_scratch_param(); // R10
    issue(0, 1, 2, 1, 3, 0, 0);
    chk("R10", "alt scratch mov rd", int'(out_rd2), 9);
    take("R10", OP_MOV, SCR, 3, 0, 0);
    chk("R10", "alt scratch add rd", int'(out_rd2), 9);
    take("R10", OP_ADD, SCR, 2, 0, 0);
    chk("R10", "alt scratch ld rs", int'(out_rs2), 9);
    take("R10", OP_LD, 1, SCR, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid reset", int'(out_valid), 0);
    chk("R1", "in_ready reset", int'(in_ready), 1);
    t_load_plain();
    t_store_plain();
    t_load_idx();
    t_store_scaled();
    t_addm();
    t_stall();
    t_scratch_param();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule